// File: doc/BRIEF.md
# Memory Range CRC-32C Engine

This block computes a CRC-32C checksum over a contiguous run of 32-bit memory words. A caller presents a start byte address and an end byte address with a one-cycle start pulse. The engine then walks the range through a synchronous read port, one word per cycle, and folds each returned word into a 32-bit checksum register. A busy flag stays high from the accepted start until the last word has been folded in.

The range is checked before any fetch. A span shorter than two words is refused: the engine stays idle and raises a single-cycle abort flag. While the engine runs, a suspend request stops its fetches and hands the read port to a second requester, called the host, whose enable and address then pass straight to memory. A resume request continues the walk at the first word that has not been fetched. The checksum is the same as for an uninterrupted pass.

Top module: `mem_range_crc`

## Requirements
- R1: Each word updates the checksum bit-serially, most significant bit first, with the generator 0x1EDC6F41. For each of the 32 bits, the feedback is checksum bit 31 XOR the input bit. The checksum shifts left by one, and the generator is XORed in when the feedback is 1.
- R2: Bytes are swapped before the word enters the update of R1. The serial input is {d[7:0], d[15:8], d[23:16], d[31:24]}, taken from bit 31 down to bit 0, where d is the word read from memory.
- R3: The checksum output is 0xFFFFFFFF after reset, including a reset that arrives during a run, and again in the cycle after any accepted start.
- R4: A start is refused when the aligned end address is less than the aligned start address plus 4. In that case busy stays 0 and the abort output is 1 for exactly one cycle after the start was sampled.
- R5: Address bits [1:0] of both the start and end addresses are ignored, so every address is treated as word aligned.
- R6: For an accepted range of N words, busy is 1 for exactly N+1 cycles when there is no suspension. It goes to 0 once the final checksum is on the output.
- R7: The engine fetches the words from the start address through the end address inclusive, in ascending order, one per cycle. A range that ends at the top of the address space completes normally.
- R8: While suspended, suspended_o and busy are 1. The engine issues no reads, the host's read enable and address appear on the memory port, and the checksum does not change.
- R9: After a resume, the walk continues at the next unfetched word, and the final checksum equals that of an uninterrupted pass over the same range.
- R10: A suspend request while idle has no effect. A resume request while not suspended has no effect. A start request while running or suspended has no effect on the range being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; addresses sampled with it |
| start_addr_i | input | ADDR_W | First byte address of the range |
| end_addr_i | input | ADDR_W | Last byte address of the range (inclusive) |
| suspend_i | input | 1 | Pause request |
| resume_i | input | 1 | Continue request |
| busy_o | output | 1 | Calculation in progress or suspended |
| suspended_o | output | 1 | Engine paused, port given to host |
| abort_o | output | 1 | One-cycle pulse on a refused range |
| crc_o | output | 32 | Checksum register |
| host_rd_en_i | input | 1 | Host read request |
| host_addr_i | input | ADDR_W | Host read byte address |
| mem_rd_en_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Memory read byte address |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the enable |

## Verification
The hardest situation to create is a suspension that lands in the cycle when a fetched word is still in flight. That word's data arrives after the port has already passed to the host, and it must still be folded in exactly once. The stimulus suspends the same 20-word walk after 1 through 6 cycles of running, so the pause falls at several pipeline positions. During each pause it drives host reads and checks that the memory port follows the host and that the checksum stays frozen. After the resume, it compares the final checksum with one computed in the bench.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_POLY   = 32'h1EDC6F41;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_HOLD = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic accept;
        logic reject;
    } start_dec_t;

    function automatic logic [31:0] order_bytes(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

endpackage

// File: rtl/crc32c_word_step.sv
module crc32c_word_step
    import crc32c_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);

    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_i;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            fb  = acc[CRC_W-1] ^ data_i[b];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        crc_o = acc;
    end

endmodule

// File: rtl/crc_range_seq.sv
module crc_range_seq
    import crc32c_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] end_addr_i,
    input  logic              suspend_i,
    input  logic              resume_i,
    output logic              eng_rd_en_o,
    output logic [ADDR_W-1:0] eng_addr_o,
    output logic              eng_own_o,
    output logic              word_valid_o,
    output logic              preset_o,
    output logic              busy_o,
    output logic              held_o,
    output logic              abort_o
);

    localparam int IDX_W = ADDR_W - 2;

    eng_state_e       state_q, state_d;
    logic [IDX_W:0]   fetch_q;
    logic [IDX_W:0]   last_q;
    logic             pend_q;
    logic             abort_q;
    logic [IDX_W-1:0] s_idx, e_idx;
    logic             range_ok;
    logic             all_issued;
    logic             issue;
    start_dec_t       dec;

    assign s_idx    = start_addr_i[ADDR_W-1:2];
    assign e_idx    = end_addr_i[ADDR_W-1:2];
    assign range_ok = {1'b0, e_idx} >= ({1'b0, s_idx} + (IDX_W+1)'(1));

    always_comb begin
        dec.accept = (state_q == ENG_IDLE) && start_i && range_ok;
        dec.reject = (state_q == ENG_IDLE) && start_i && !range_ok;
    end

    assign all_issued = fetch_q > last_q;
    assign issue      = (state_q == ENG_RUN) && !all_issued;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (dec.accept) state_d = ENG_RUN;
            ENG_RUN: begin
                if (all_issued)     state_d = ENG_IDLE;
                else if (suspend_i) state_d = ENG_HOLD;
            end
            ENG_HOLD: if (resume_i) state_d = ENG_RUN;
            default:  state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            fetch_q <= '0;
            last_q  <= '0;
            pend_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= issue;
            abort_q <= dec.reject;
            if (dec.accept) begin
                fetch_q <= {1'b0, s_idx};
                last_q  <= {1'b0, e_idx};
            end else if (issue) begin
                fetch_q <= fetch_q + (IDX_W+1)'(1);
            end
        end
    end

    assign eng_rd_en_o  = issue;
    assign eng_addr_o   = {fetch_q[IDX_W-1:0], 2'b00};
    assign eng_own_o    = (state_q == ENG_RUN);
    assign word_valid_o = pend_q;
    assign preset_o     = dec.accept;
    assign busy_o       = (state_q != ENG_IDLE);
    assign held_o       = (state_q == ENG_HOLD);
    assign abort_o      = abort_q;

    // R7: back-to-back fetches step by one word
    a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
        (eng_rd_en_o && $past(eng_rd_en_o)) |-> eng_addr_o == $past(eng_addr_o) + ADDR_W'(4));

    // R8: no engine reads while paused
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        held_o |-> !eng_rd_en_o);

    // R4: refused range gives a pulse and leaves the engine idle
    a_r4_reject: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !range_ok) |=> (abort_o && !busy_o));

    // R4: abort only while idle
    a_r4_abort_idle: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> !busy_o);

    // R10: pause persists until resumed
    a_r10_hold_stays: assert property (@(posedge clk) disable iff (rst)
        (held_o && !resume_i) |=> held_o);

    // R10: suspend while idle changes nothing
    a_r10_idle_suspend: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i && suspend_i) |=> (!busy_o && !held_o));

endmodule

// File: rtl/crc_port_arbiter.sv
module crc_port_arbiter #(
    parameter int ADDR_W = 10
) (
    input  logic              eng_own_i,
    input  logic              eng_rd_en_i,
    input  logic [ADDR_W-1:0] eng_addr_i,
    input  logic              host_rd_en_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o
);

    always_comb begin
        if (eng_own_i) begin
            mem_rd_en_o = eng_rd_en_i;
            mem_addr_o  = eng_addr_i;
        end else begin
            mem_rd_en_o = host_rd_en_i;
            mem_addr_o  = host_addr_i;
        end
    end

endmodule

// File: rtl/mem_range_crc.sv
module mem_range_crc
    import crc32c_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] end_addr_i,
    input  logic              suspend_i,
    input  logic              resume_i,
    output logic              busy_o,
    output logic              suspended_o,
    output logic              abort_o,
    output logic [31:0]       crc_o,
    input  logic              host_rd_en_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [31:0]       mem_rdata_i
);

    logic              eng_rd_en;
    logic [ADDR_W-1:0] eng_addr;
    logic              eng_own;
    logic              word_valid;
    logic              preset;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_next;

    crc_range_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .end_addr_i   (end_addr_i),
        .suspend_i    (suspend_i),
        .resume_i     (resume_i),
        .eng_rd_en_o  (eng_rd_en),
        .eng_addr_o   (eng_addr),
        .eng_own_o    (eng_own),
        .word_valid_o (word_valid),
        .preset_o     (preset),
        .busy_o       (busy_o),
        .held_o       (suspended_o),
        .abort_o      (abort_o)
    );

    crc_port_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .eng_own_i    (eng_own),
        .eng_rd_en_i  (eng_rd_en),
        .eng_addr_i   (eng_addr),
        .host_rd_en_i (host_rd_en_i),
        .host_addr_i  (host_addr_i),
        .mem_rd_en_o  (mem_rd_en_o),
        .mem_addr_o   (mem_addr_o)
    );

    crc32c_word_step #(.DATA_W(32)) u_step (
        .crc_i  (crc_q),
        .data_i (order_bytes(mem_rdata_i)),
        .crc_o  (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst)             crc_q <= CRC_PRESET;
        else if (preset)     crc_q <= CRC_PRESET;
        else if (word_valid) crc_q <= crc_next;
    end

    assign crc_o = crc_q;

    // R3: accepted start presets the checksum
    a_r3_preset: assert property (@(posedge clk) disable iff (rst)
        preset |=> crc_o == CRC_PRESET);

    // R8: paused engine lends the port to the host
    a_r8_host_port: assert property (@(posedge clk) disable iff (rst)
        suspended_o |-> (mem_rd_en_o == host_rd_en_i && mem_addr_o == host_addr_i));

    // R6: busy drops only once no fetched word is outstanding
    a_r6_done_clean: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> !word_valid);

    // R8: checksum frozen across a pause once the in-flight word is absorbed
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (suspended_o && $past(suspended_o)) |=> $stable(crc_o));

endmodule

// File: tb/mem_range_crc_test.sv
module mem_range_crc_test;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [AW-1:0] end_addr_i = '0;
    logic          suspend_i = 1'b0;
    logic          resume_i = 1'b0;
    logic          busy_o, suspended_o, abort_o;
    logic [31:0]   crc_o;
    logic          host_rd_en_i = 1'b0;
    logic [AW-1:0] host_addr_i = '0;
    logic          mem_rd_en_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0]   mem_rdata_i = '0;

    logic [31:0] mem [0:255];
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mem_range_crc #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .end_addr_i(end_addr_i), .suspend_i(suspend_i), .resume_i(resume_i),
        .busy_o(busy_o), .suspended_o(suspended_o), .abort_o(abort_o), .crc_o(crc_o),
        .host_rd_en_i(host_rd_en_i), .host_addr_i(host_addr_i),
        .mem_rd_en_o(mem_rd_en_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
    );

    always @(posedge clk) if (mem_rd_en_o) mem_rdata_i <= mem[mem_addr_o[AW-1:2]];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int sw, input int ew);
        logic [31:0] c, d, s;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int w = sw; w <= ew; w++) begin
            d = mem[w];
            s = {d[7:0], d[15:8], d[23:16], d[31:24]};
            for (int b = 31; b >= 0; b--) begin
                fb = c[31] ^ s[b];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h1EDC6F41;
            end
        end
        return c;
    endfunction

    task automatic pulse_start(input logic [AW-1:0] s, input logic [AW-1:0] e);
        start_i = 1'b1; start_addr_i = s; end_addr_i = e;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy_o && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] snap;
        for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h0F1E2D3C;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(crc_o == 32'hFFFF_FFFF, "R3 reset crc", crc_o, 32'hFFFF_FFFF);
        chk(!busy_o && !suspended_o && !abort_o, "R3 reset flags",
            {29'd0, busy_o, suspended_o, abort_o}, 32'd0);

        // R1 R2 R5 R6 R7: sweep of start and length with junk low bits
        for (int si = 0; si < 8; si++) begin
            for (int li = 2; li <= 9; li++) begin
                int sw, ew;
                sw = si * 5;
                ew = sw + li - 1;
                pulse_start(AW'(sw * 4 + si % 4), AW'(ew * 4 + (li * 3) % 4));
                wait_idle(cyc);
                chk(cyc == li + 1, "R6 busy length", 32'(cyc), 32'(li + 1));
                chk(crc_o == ref_crc(sw, ew), "R1 R2 R5 R7 checksum", crc_o, ref_crc(sw, ew));
            end
        end

        // R7: range at the top of the address space
        pulse_start(10'h3F0, 10'h3FF);
        wait_idle(cyc);
        chk(cyc == 5, "R7 top busy", 32'(cyc), 32'd5);
        chk(crc_o == ref_crc(252, 255), "R7 top checksum", crc_o, ref_crc(252, 255));

        // R4: refused ranges
        begin
            logic [AW-1:0] bs [0:2];
            logic [AW-1:0] be [0:2];
            bs[0] = 10'h100; be[0] = 10'h100;
            bs[1] = 10'h100; be[1] = 10'h0FC;
            bs[2] = 10'h104; be[2] = 10'h107;
            for (int k = 0; k < 3; k++) begin
                pulse_start(bs[k], be[k]);
                chk(abort_o && !busy_o, "R4 abort pulse", {30'd0, abort_o, busy_o}, 32'd2);
                @(negedge clk);
                chk(!abort_o && !busy_o, "R4 abort one cycle", {30'd0, abort_o, busy_o}, 32'd0);
            end
        end

        // R10: suspend while idle
        suspend_i = 1'b1; @(negedge clk); suspend_i = 1'b0;
        chk(!suspended_o && !busy_o, "R10 idle suspend", {30'd0, suspended_o, busy_o}, 32'd0);
        pulse_start(10'h010, 10'h01C);
        wait_idle(cyc);
        chk(crc_o == ref_crc(4, 7), "R10 after idle suspend", crc_o, ref_crc(4, 7));

        // R8 R9: suspension at several pipeline positions
        for (int k = 1; k <= 6; k++) begin
            pulse_start(10'h040, 10'h040 + 10'd76);
            repeat (k - 1) @(negedge clk);
            suspend_i = 1'b1; @(negedge clk); suspend_i = 1'b0;
            chk(suspended_o && busy_o, "R8 paused flags", {30'd0, suspended_o, busy_o}, 32'd3);
            chk(!mem_rd_en_o, "R8 no engine read", {31'd0, mem_rd_en_o}, 32'd0);
            @(negedge clk);
            snap = crc_o;
            host_rd_en_i = 1'b1; host_addr_i = AW'(10'h200 + k * 4);
            #1;
            chk(mem_rd_en_o && mem_addr_o == host_addr_i, "R8 host owns port",
                {21'd0, mem_rd_en_o, mem_addr_o}, {21'd0, 1'b1, host_addr_i});
            repeat (3) @(negedge clk);
            host_rd_en_i = 1'b0;
            chk(crc_o == snap, "R8 crc frozen", crc_o, snap);
            resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
            wait_idle(cyc);
            chk(crc_o == ref_crc(16, 35), "R9 resumed checksum", crc_o, ref_crc(16, 35));
        end

        // R10: resume and restart while running are ignored
        pulse_start(10'h080, 10'h09C);
        resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
        start_i = 1'b1; start_addr_i = 10'h000; end_addr_i = 10'h3FC;
        @(negedge clk); start_i = 1'b0;
        wait_idle(cyc);
        chk(cyc == 7, "R10 busy unchanged", 32'(cyc + 2), 32'd9);
        chk(crc_o == ref_crc(32, 39), "R10 checksum unchanged", crc_o, ref_crc(32, 39));

        // R10: restart while suspended is ignored
        pulse_start(10'h080, 10'h09C);
        suspend_i = 1'b1; @(negedge clk); suspend_i = 1'b0;
        pulse_start(10'h000, 10'h004);
        chk(suspended_o, "R10 start while paused", {31'd0, suspended_o}, 32'd1);
        resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
        wait_idle(cyc);
        chk(crc_o == ref_crc(32, 39), "R10 paused restart checksum", crc_o, ref_crc(32, 39));

        // R3: reset during a run
        pulse_start(10'h000, 10'h0FC);
        repeat (3) @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk(!busy_o && crc_o == 32'hFFFF_FFFF, "R3 mid-run reset", crc_o, 32'hFFFF_FFFF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule